// File: doc/BRIEF.md
# 32-bit SEC-DED Codec with Separate Check Field

This block protects a 32-bit word with seven check bits held in a field of their own, next to the data word rather than interleaved with it. Six check bits allow one flipped bit to be corrected. The seventh bit is an overall even parity bit, and it allows two flipped bits to be detected. The encoder side is purely combinational and turns a data word into its 7-bit check field.

The decoder side takes a received data word and check field. It recomputes the six coverage checks from the received data and forms a syndrome. From the syndrome and the overall parity it decides whether the word holds no error, one error or two errors. When a single error hits the data, the position of the bad bit is worked out arithmetically from the syndrome and that bit is flipped back. When a single error hits the check field, it is flagged but nothing is repaired.

All decoder results pass through one register stage, together with a valid strobe that is delayed by one cycle.

Top module: `secded32_codec`

## Requirements
- R1: `enc_check[5:0]` holds the six coverage checks, with data bit 0 as the least significant bit. Check k, for k from 0 to 4, is the XOR of data bit 0 and every data bit i (1 to 31) whose index has bit k set. Check 5 is the XOR of data bits 1 to 31.
- R2: `enc_check[6]` makes the XOR of all 32 data bits and all 7 check bits equal zero.
- R3: A received word with even overall parity and a zero syndrome gives `dec_err_count`=0 and `dec_check_err`=0, and the data passes through unchanged. The syndrome is the received check bits [5:0] XOR the checks recomputed from the received data.
- R4: A single flipped data bit is repaired, with `dec_err_count`=1 and `dec_check_err`=0. Syndrome 011111 points at data bit 0. A syndrome of the form 1xxxxx with xxxxx nonzero points at data bit xxxxx. As an example, flipping bit 4 gives syndrome 100100.
- R5: A single flipped check-field bit (any of bits 0 to 6) gives `dec_err_count`=1 and `dec_check_err`=1. This case is odd parity with at most one syndrome bit set. The data passes through unchanged.
- R6: Two flipped bits anywhere give `dec_err_count`=2 and `dec_check_err`=0. This case is even parity with a nonzero syndrome. The data passes through unchanged.
- R7: Odd overall parity with a syndrome that names neither a check bit nor a data bit gives `dec_err_count`=2, and the data is left unchanged. An example is a syndrome of the form 0xxxxx with two or more bits set, other than 011111.
- R8: The decoder results appear one clock after the input. `dec_valid_out` is `dec_valid_in` delayed by one cycle.
- R9: While `dec_valid_in` is low, the decoder data, count and flag outputs hold their values.
- R10: While reset is held, `dec_valid_out`, `dec_err_count`, `dec_check_err` and `dec_data_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_data | input | 32 | Word to be encoded |
| enc_check | output | 7 | Check field computed for `enc_data` |
| dec_valid_in | input | 1 | Received word is present |
| dec_data_in | input | 32 | Received data word |
| dec_check_in | input | 7 | Received check field |
| dec_valid_out | output | 1 | Registered results are valid |
| dec_data_out | output | 32 | Corrected data |
| dec_err_count | output | 2 | Number of errors found: 0, 1 or 2 |
| dec_check_err | output | 1 | The single error lies in the check field |

## Verification
The hardest case to reach from the ports is odd overall parity paired with a syndrome that fits no single-error pattern. No single or double error can produce it.

The bench reaches this case with a triple error: it flips data bits 1 and 2 and the overall parity bit, which yields syndrome 000011. The other vectors take clean codewords from an independent mask-based model and flip chosen bits. The flipped bits are placed on data bit 0, data bit 31, the top check bit and pairs that mix data and check bits.

// File: rtl/secded32_codec.sv
module secded32_codec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] enc_data,
  output logic [6:0]  enc_check,
  input  logic        dec_valid_in,
  input  logic [31:0] dec_data_in,
  input  logic [6:0]  dec_check_in,
  output logic        dec_valid_out,
  output logic [31:0] dec_data_out,
  output logic [1:0]  dec_err_count,
  output logic        dec_check_err
);

  function automatic logic [5:0] cover6(input logic [31:0] d);
    logic [5:0] c;
    c = '0;
    for (int i = 1; i < 32; i++) begin
      for (int k = 0; k < 5; k++)
        if (((i >> k) & 1) == 1) c[k] = c[k] ^ d[i];
      c[5] = c[5] ^ d[i];
    end
    if (d[0]) c[4:0] = ~c[4:0];
    return c;
  endfunction

  logic [5:0] enc_c6;
  assign enc_c6    = cover6(enc_data);
  assign enc_check = {^{enc_data, enc_c6}, enc_c6};

  logic [5:0]  syn;
  logic        odd, one_hot, hit_b0, hit_hi;
  logic [4:0]  pos;
  logic [1:0]  cnt;
  logic        ce, fix;
  logic [31:0] flip;

  assign syn     = cover6(dec_data_in) ^ dec_check_in[5:0];
  assign odd     = ^{dec_data_in, dec_check_in};
  assign one_hot = (syn & (syn - 6'd1)) == 6'd0;
  assign hit_b0  = syn == 6'b011111;
  assign hit_hi  = syn[5] && (syn[4:0] != 5'd0);
  assign pos     = hit_b0 ? 5'd0 : syn[4:0];
  assign flip    = fix ? (32'd1 << pos) : 32'd0;

  always_comb begin
    cnt = 2'd0;
    ce  = 1'b0;
    fix = 1'b0;
    if (!odd) begin
      cnt = (syn == 6'd0) ? 2'd0 : 2'd2;
    end else if (one_hot) begin
      cnt = 2'd1;
      ce  = 1'b1;
    end else if (hit_b0 || hit_hi) begin
      cnt = 2'd1;
      fix = 1'b1;
    end else begin
      cnt = 2'd2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid_out <= 1'b0;
      dec_data_out  <= '0;
      dec_err_count <= 2'd0;
      dec_check_err <= 1'b0;
    end else begin
      dec_valid_out <= dec_valid_in;
      if (dec_valid_in) begin
        dec_data_out  <= dec_data_in ^ flip;
        dec_err_count <= cnt;
        dec_check_err <= ce;
      end
    end
  end

endmodule

// File: rtl/secded32_codec_chk.sv
module secded32_codec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dec_valid_in,
  input logic [31:0] dec_data_in,
  input logic        dec_valid_out,
  input logic [31:0] dec_data_out,
  input logic [1:0]  dec_err_count,
  input logic        dec_check_err
);

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_in |=> dec_valid_out);

  assert_valid_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_in |=> !dec_valid_out);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_in |=> ($stable(dec_data_out) && $stable(dec_err_count) && $stable(dec_check_err)));

  assert_clean_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_out && dec_err_count == 2'd0) |-> (!dec_check_err && dec_data_out == $past(dec_data_in)));

  assert_one_fix_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_out && dec_err_count == 2'd1 && !dec_check_err) |->
      $countones(dec_data_out ^ $past(dec_data_in)) == 1);

  assert_check_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_out && dec_check_err) |-> (dec_err_count == 2'd1 && dec_data_out == $past(dec_data_in)));

  assert_double_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_out && dec_err_count == 2'd2) |-> (!dec_check_err && dec_data_out == $past(dec_data_in)));

  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err_count != 2'd3);

endmodule

bind secded32_codec secded32_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid_in(dec_valid_in), .dec_data_in(dec_data_in),
  .dec_valid_out(dec_valid_out), .dec_data_out(dec_data_out),
  .dec_err_count(dec_err_count), .dec_check_err(dec_check_err)
);

// File: tb/test_secded32_codec.sv
module test_secded32_codec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] enc_data = '0;
  logic [6:0]  enc_check;
  logic        dec_valid_in = 1'b0;
  logic [31:0] dec_data_in = '0;
  logic [6:0]  dec_check_in = '0;
  logic        dec_valid_out;
  logic [31:0] dec_data_out;
  logic [1:0]  dec_err_count;
  logic        dec_check_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  secded32_codec i_secded32_codec (
    .clk(clk), .rst_n(rst_n), .enc_data(enc_data), .enc_check(enc_check),
    .dec_valid_in(dec_valid_in), .dec_data_in(dec_data_in), .dec_check_in(dec_check_in),
    .dec_valid_out(dec_valid_out), .dec_data_out(dec_data_out),
    .dec_err_count(dec_err_count), .dec_check_err(dec_check_err)
  );

  function automatic logic [6:0] model_check(input logic [31:0] d);
    logic [5:0] c;
    c[0] = ^(d & 32'hAAAAAAAB);
    c[1] = ^(d & 32'hCCCCCCCD);
    c[2] = ^(d & 32'hF0F0F0F1);
    c[3] = ^(d & 32'hFF00FF01);
    c[4] = ^(d & 32'hFFFF0001);
    c[5] = ^(d & 32'hFFFFFFFE);
    return {^{d, c}, c};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam int NV = 13;
  localparam logic [73:0] VEC [NV] = '{
    {32'h00000000, 32'h00000000, 7'h00, 2'd0, 1'b0},
    {32'hFFFFFFFF, 32'h00000000, 7'h00, 2'd0, 1'b0},
    {32'h12345678, 32'h00000010, 7'h00, 2'd1, 1'b0},
    {32'hA5A5A5A5, 32'h00000001, 7'h00, 2'd1, 1'b0},
    {32'hDEADBEEF, 32'h80000000, 7'h00, 2'd1, 1'b0},
    {32'h0F0F0F0F, 32'h00000000, 7'h01, 2'd1, 1'b1},
    {32'h13579BDF, 32'h00000000, 7'h20, 2'd1, 1'b1},
    {32'h2468ACE0, 32'h00000000, 7'h40, 2'd1, 1'b1},
    {32'hCAFEF00D, 32'h00000088, 7'h00, 2'd2, 1'b0},
    {32'h87654321, 32'h00000001, 7'h01, 2'd2, 1'b0},
    {32'h00000000, 32'h00000000, 7'h03, 2'd2, 1'b0},
    {32'h55AA55AA, 32'h00000006, 7'h40, 2'd2, 1'b0},
    {32'h0000FFFF, 32'h00010000, 7'h00, 2'd1, 1'b0}
  };

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    dec_valid_in = 1'b1;
    dec_data_in  = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    check(dec_valid_out == 1'b0 && dec_err_count == 2'd0 && dec_check_err == 1'b0 && dec_data_out == 32'd0,
          "R10 reset state", {dec_valid_out, dec_err_count, dec_check_err, dec_data_out}, 64'd0);
    dec_valid_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] d, df, exp_d;
      logic [6:0]  cf, ck;
      logic [1:0]  ec;
      logic        ee;
      {d, df, cf, ec, ee} = VEC[v];
      ck = model_check(d);
      enc_data     = d;
      dec_valid_in = 1'b1;
      dec_data_in  = d ^ df;
      dec_check_in = ck ^ cf;
      exp_d = (ec == 2'd1 && !ee) ? d : (d ^ df);
      #1;
      check(enc_check[5:0] == ck[5:0], "R1 coverage checks", enc_check[5:0], ck[5:0]);
      check(enc_check[6] == ck[6], "R2 overall parity", enc_check[6], ck[6]);
      @(negedge clk);
      check(dec_valid_out == 1'b1, "R8 valid delayed", dec_valid_out, 1);
      check(dec_err_count == ec, (ec == 0) ? "R3 count" : (ee ? "R5 count" : (ec == 1 ? "R4 count" : (v == 11 ? "R7 count" : "R6 count"))),
            dec_err_count, ec);
      check(dec_check_err == ee, ee ? "R5 flag" : "R4 R6 flag", dec_check_err, ee);
      check(dec_data_out == exp_d, (ec == 1 && !ee) ? "R4 data" : "R3 R5 R6 R7 data", dec_data_out, exp_d);
    end

    dec_valid_in = 1'b1;
    dec_data_in  = 32'h0BADF00D;
    dec_check_in = model_check(32'h0BADF00D) ^ 7'h04;
    @(negedge clk);
    dec_valid_in = 1'b0;
    dec_data_in  = 32'h11111111;
    dec_check_in = 7'h00;
    @(negedge clk);
    check(dec_valid_out == 1'b0, "R8 valid drops", dec_valid_out, 0);
    check(dec_data_out == 32'h0BADF00D && dec_err_count == 2'd1 && dec_check_err == 1'b1,
          "R9 hold", {dec_err_count, dec_check_err, dec_data_out}, {2'd1, 1'b1, 32'h0BADF00D});
    @(negedge clk);
    check(dec_data_out == 32'h0BADF00D, "R9 hold second cycle", dec_data_out, 32'h0BADF00D);

    for (int b = 0; b < 32; b++) begin
      logic [31:0] d;
      d = 32'h6C3A9E51 + b;
      dec_valid_in = 1'b1;
      dec_data_in  = d ^ (32'd1 << b);
      dec_check_in = model_check(d);
      @(negedge clk);
      check(dec_data_out == d && dec_err_count == 2'd1 && !dec_check_err, "R4 sweep",
            {dec_err_count, dec_check_err, dec_data_out}, {2'd1, 1'b0, d});
    end
    dec_valid_in = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule